// File: doc/BRIEF.md
# Reservation Station Wakeup and Select

This block holds a small pool of renamed instructions that wait for one class of functional unit. Each instruction has a destination tag and two source operands. When it arrives, each source is either a finished value or the tag of the instruction that will produce it. A single result bus carries a tag and a value. Every waiting source compares its tag against that bus, and on a match it copies the value and becomes ready.

An instruction whose two sources are both ready is awake. Each cycle, a selector picks one awake instruction and presents it on the issue port. When more than one is awake, the oldest one wins. Instructions therefore leave in dataflow order rather than program order. The insert port stalls the front end while no entry is free. An entry that issues becomes free again on the following cycle.

Top module: `rs_wakeup_select`

## Requirements
- R1: After reset the pool is empty: `ins_ready_o` is 1 and `iss_valid_o` is 0. `ins_ready_o` is 1 exactly when at least one entry is free.
- R2: A source marked ready at insertion (`ins_src_rdy_i[s]`=1) keeps the inserted value unchanged until the entry issues.
- R3: A waiting source whose tag equals `bc_tag_i` while `bc_valid_i` is 1 captures `bc_val_i`. It counts as ready from the next cycle.
- R4: A broadcast in the same cycle as an insertion is compared against the incoming source tags. A match captures the value, so the wakeup is not lost.
- R5: `iss_valid_o` is 1 exactly when some held entry has both sources ready.
- R6: Among awake entries, the one inserted earliest is presented on the issue port. Its destination tag and both source values appear on `iss_dst_o` and `iss_src_o`.
- R7: A younger entry that is awake issues ahead of an older entry that is still waiting.
- R8: An issue completes in a cycle where `iss_valid_o` and `iss_ready_i` are both 1. The entry then frees and can be allocated again in the next cycle. While `iss_ready_i` is 0, the awake entry stays held and `iss_valid_o` stays 1.
- R9: With every entry occupied, `ins_ready_o` is 0 and an insert request is ignored. The ignored instruction never appears on the issue port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ins_valid_i | input | 1 | Insert request |
| ins_ready_o | output | 1 | A free entry exists |
| ins_dst_i | input | TAG_W | Destination tag of the incoming instruction |
| ins_src_rdy_i | input | 2 | Per source: 1 means the value field is valid |
| ins_src_tag_i | input | 2*TAG_W | Per source producer tag, used when not ready |
| ins_src_val_i | input | 2*DATA_W | Per source value, used when ready |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TAG_W | Broadcast producer tag |
| bc_val_i | input | DATA_W | Broadcast result value |
| iss_valid_o | output | 1 | An awake entry is presented |
| iss_ready_i | input | 1 | Functional unit accepts the presented entry |
| iss_dst_o | output | TAG_W | Destination tag of the presented entry |
| iss_src_o | output | 2*DATA_W | Both source values of the presented entry |

## Verification
The checks assume that `iss_ready_i` is only meaningful while `iss_valid_o` is high. They also assume that broadcast tags and source tags use one shared tag space, and that any tag match means the value has arrived. The stimulus keeps producer tags in a narrow range, so broadcasts often hit one or several waiting sources, including sources that are being inserted in the same cycle. Stretches with the issue port back-pressured fill the pool, so that full-pool insert attempts and reallocation right after an issue both occur.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned NUM_SRC = 2;

  function automatic int unsigned idx_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AGE_W  = 2
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       alloc_i,
  input  logic                                       clear_i,
  input  logic [AGE_W-1:0]                           age_ld_i,
  input  logic [TAG_W-1:0]                           dst_i,
  input  logic [rs_pkg::NUM_SRC-1:0]                 rdy_i,
  input  logic [rs_pkg::NUM_SRC-1:0][TAG_W-1:0]      tag_i,
  input  logic [rs_pkg::NUM_SRC-1:0][DATA_W-1:0]     val_i,
  input  logic                                       bc_valid_i,
  input  logic [TAG_W-1:0]                           bc_tag_i,
  input  logic [DATA_W-1:0]                          bc_val_i,
  input  logic                                       rm_valid_i,
  input  logic [AGE_W-1:0]                           rm_age_i,
  output logic                                       valid_o,
  output logic                                       awake_o,
  output logic [AGE_W-1:0]                           age_o,
  output logic [TAG_W-1:0]                           dst_o,
  output logic [rs_pkg::NUM_SRC-1:0][DATA_W-1:0]     val_o
);
  localparam int unsigned NS = rs_pkg::NUM_SRC;

  logic                          valid_q;
  logic [AGE_W-1:0]              age_q;
  logic [TAG_W-1:0]              dst_q;
  logic [NS-1:0]                 rdy_q;
  logic [NS-1:0][TAG_W-1:0]      tag_q;
  logic [NS-1:0][DATA_W-1:0]     val_q;
  logic [NS-1:0]                 hit_new, hit_old;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      hit_new[s] = bc_valid_i && (bc_tag_i == tag_i[s]);
      hit_old[s] = bc_valid_i && valid_q && !rdy_q[s] && (bc_tag_i == tag_q[s]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      age_q   <= '0;
      dst_q   <= '0;
      rdy_q   <= '0;
      tag_q   <= '0;
      val_q   <= '0;
    end else begin
      if (clear_i) begin
        valid_q <= 1'b0;
      end else if (alloc_i) begin
        valid_q <= 1'b1;
        age_q   <= age_ld_i;
        dst_q   <= dst_i;
      end else if (valid_q && rm_valid_i && (age_q > rm_age_i)) begin
        age_q <= age_q - 1'b1;
      end
      for (int s = 0; s < NS; s++) begin
        if (alloc_i) begin
          tag_q[s] <= tag_i[s];
          if (rdy_i[s]) begin
            rdy_q[s] <= 1'b1;
            val_q[s] <= val_i[s];
          end else if (hit_new[s]) begin
            // same-cycle broadcast caught on the way in
            rdy_q[s] <= 1'b1;
            val_q[s] <= bc_val_i;
          end else begin
            rdy_q[s] <= 1'b0;
          end
        end else if (hit_old[s]) begin
          rdy_q[s] <= 1'b1;
          val_q[s] <= bc_val_i;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign awake_o = valid_q && (&rdy_q);
  assign age_o   = age_q;
  assign dst_o   = dst_q;
  assign val_o   = val_q;

  for (genvar g = 0; g < NS; g++) begin : g_src_chk
    p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q && !clear_i && !rdy_q[g] && bc_valid_i && (bc_tag_i == tag_q[g])
      |=> rdy_q[g] && (val_q[g] == $past(bc_val_i)));
    p_insert_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alloc_i && rdy_i[g] |=> rdy_q[g] && (val_q[g] == $past(val_i[g])));
    p_keep_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q && !clear_i && rdy_q[g] |=> rdy_q[g] && $stable(val_q[g]));
  end
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int unsigned ENTRIES = 4
) (
  input  logic [ENTRIES-1:0] free_i,
  output logic [ENTRIES-1:0] gnt_o,
  output logic               any_o
);
  logic found;

  // lowest free index wins
  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (free_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned AGE_W   = 2
) (
  input  logic [ENTRIES-1:0]            awake_i,
  input  logic [ENTRIES-1:0][AGE_W-1:0] age_i,
  output logic [ENTRIES-1:0]            sel_o,
  output logic                          any_o
);
  // ages are unique among held entries; smallest age is oldest
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      sel_o[i] = awake_i[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && awake_i[j] && (age_i[j] < age_i[i])) sel_o[i] = 1'b0;
      end
    end
    any_o = |awake_i;
  end
endmodule

// File: rtl/rs_wakeup_select.sv
module rs_wakeup_select #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ins_valid_i,
  output logic                   ins_ready_o,
  input  logic [TAG_W-1:0]       ins_dst_i,
  input  logic [1:0]             ins_src_rdy_i,
  input  logic [1:0][TAG_W-1:0]  ins_src_tag_i,
  input  logic [1:0][DATA_W-1:0] ins_src_val_i,
  input  logic                   bc_valid_i,
  input  logic [TAG_W-1:0]       bc_tag_i,
  input  logic [DATA_W-1:0]      bc_val_i,
  output logic                   iss_valid_o,
  input  logic                   iss_ready_i,
  output logic [TAG_W-1:0]       iss_dst_o,
  output logic [1:0][DATA_W-1:0] iss_src_o
);
  localparam int unsigned AGE_W = rs_pkg::idx_w(ENTRIES);
  localparam int unsigned CNT_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0]                  valid, awake, gnt, sel, alloc, clear;
  logic [ENTRIES-1:0][AGE_W-1:0]       age;
  logic [ENTRIES-1:0][TAG_W-1:0]       dst;
  logic [ENTRIES-1:0][1:0][DATA_W-1:0] val;
  logic                                any_free, any_awake, ins_fire, iss_fire;
  logic [AGE_W-1:0]                    rm_age;
  logic [CNT_W-1:0]                    keep_cnt;

  rs_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .free_i (~valid),
    .gnt_o  (gnt),
    .any_o  (any_free)
  );

  rs_select #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_select (
    .awake_i (awake),
    .age_i   (age),
    .sel_o   (sel),
    .any_o   (any_awake)
  );

  assign ins_ready_o = any_free;
  assign ins_fire    = ins_valid_i && any_free;
  assign iss_valid_o = any_awake;
  assign iss_fire    = any_awake && iss_ready_i;
  assign alloc       = gnt & {ENTRIES{ins_fire}};
  assign clear       = sel & {ENTRIES{iss_fire}};

  // new entry's age = number of entries that stay after this edge
  always_comb begin
    keep_cnt  = '0;
    rm_age    = '0;
    iss_dst_o = '0;
    iss_src_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      keep_cnt = keep_cnt + CNT_W'(valid[i] && !clear[i]);
      if (sel[i]) begin
        rm_age    = rm_age | age[i];
        iss_dst_o = iss_dst_o | dst[i];
        iss_src_o = iss_src_o | val[i];
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .AGE_W(AGE_W)) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (alloc[g]),
      .clear_i    (clear[g]),
      .age_ld_i   (keep_cnt[AGE_W-1:0]),
      .dst_i      (ins_dst_i),
      .rdy_i      (ins_src_rdy_i),
      .tag_i      (ins_src_tag_i),
      .val_i      (ins_src_val_i),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_val_i   (bc_val_i),
      .rm_valid_i (iss_fire),
      .rm_age_i   (rm_age),
      .valid_o    (valid[g]),
      .awake_o    (awake[g]),
      .age_o      (age[g]),
      .dst_o      (dst[g]),
      .val_o      (val[g])
    );
  end

  p_one_issue_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  p_sel_awake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> |(sel & awake));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o && !iss_ready_i |=> iss_valid_o);
  p_free_after_issue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_ready_o && iss_fire |=> ins_ready_o);
  p_full_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_ready_o && !iss_fire |=> !ins_ready_o);
endmodule

// File: tb/tb_rs_wakeup_select.sv
module tb_rs_wakeup_select;
  localparam int N      = 4;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 16;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [TAG_W-1:0]  dst;
    bit                r   [2];
    logic [TAG_W-1:0]  t   [2];
    logic [DATA_W-1:0] v   [2];
  } ent_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, bc_valid = 1'b0, iss_ready = 1'b0;
  logic [TAG_W-1:0] ins_dst = '0, bc_tag = '0;
  logic [1:0] ins_rdy = '0;
  logic [1:0][TAG_W-1:0] ins_tag = '0;
  logic [1:0][DATA_W-1:0] ins_val = '0;
  logic [DATA_W-1:0] bc_val = '0;
  logic ins_ready, iss_valid;
  logic [TAG_W-1:0] iss_dst;
  logic [1:0][DATA_W-1:0] iss_src;

  int checks = 0, fails = 0;
  ent_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_wakeup_select #(.ENTRIES(N), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_ready_o(ins_ready), .ins_dst_i(ins_dst),
    .ins_src_rdy_i(ins_rdy), .ins_src_tag_i(ins_tag), .ins_src_val_i(ins_val),
    .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_val_i(bc_val),
    .iss_valid_o(iss_valid), .iss_ready_i(iss_ready),
    .iss_dst_o(iss_dst), .iss_src_o(iss_src)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int first_awake();
    for (int i = 0; i < q.size(); i++)
      if (q[i].r[0] && q[i].r[1]) return i;
    return -1;
  endfunction

  // compare outputs, drive inputs, advance model, wait one cycle
  task automatic step(bit iv, logic [TAG_W-1:0] d, logic [1:0] rd,
                      logic [TAG_W-1:0] t0, logic [TAG_W-1:0] t1,
                      logic [DATA_W-1:0] v0, logic [DATA_W-1:0] v1,
                      bit bv, logic [TAG_W-1:0] bt, logic [DATA_W-1:0] bvl, bit ir);
    int a;
    bit exp_rdy;
    ent_t e;
    a = first_awake();
    exp_rdy = (q.size() < N);
    chk("R1 ins_ready", 32'(ins_ready), 32'(exp_rdy));
    chk("R5 iss_valid", 32'(iss_valid), 32'(a >= 0));
    if (a >= 0) begin
      chk("R6 iss_dst", 32'(iss_dst), 32'(q[a].dst));
      chk("R3 iss_src0", 32'(iss_src[0]), 32'(q[a].v[0]));
      chk("R3 iss_src1", 32'(iss_src[1]), 32'(q[a].v[1]));
    end
    ins_valid = iv; ins_dst = d; ins_rdy = rd;
    ins_tag[0] = t0; ins_tag[1] = t1; ins_val[0] = v0; ins_val[1] = v1;
    bc_valid = bv; bc_tag = bt; bc_val = bvl; iss_ready = ir;
    if (a >= 0 && ir) q.delete(a);
    foreach (q[i])
      for (int s = 0; s < 2; s++)
        if (!q[i].r[s] && bv && q[i].t[s] == bt) begin q[i].r[s] = 1; q[i].v[s] = bvl; end
    if (iv && exp_rdy) begin
      e.dst = d;
      e.t[0] = t0; e.t[1] = t1;
      for (int s = 0; s < 2; s++) begin
        e.r[s] = rd[s] || (bv && bt == e.t[s]);
        e.v[s] = rd[s] ? (s == 0 ? v0 : v1) : (bv && bt == e.t[s]) ? bvl : '0;
      end
      q.push_back(e);
    end
    @(negedge clk);
  endtask

  task automatic idle(bit ir);
    step(0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, ir);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ins_ready", 32'(ins_ready), 1);
    chk("R1 reset iss_valid", 32'(iss_valid), 0);

    // R7: older A waits on tag 9, younger B is ready
    step(1, 4'd1, 2'b10, 4'd9, 0, 0, 16'h1111, 0, 0, 0, 0);
    step(1, 4'd2, 2'b11, 0, 0, 16'h2222, 16'h2323, 0, 0, 0, 0);
    chk("R7 younger issues first", 32'(iss_dst), 2);
    step(0, 0, 0, 0, 0, 0, 0, 1, 4'd9, 16'hABCD, 1);
    chk("R3 captured broadcast", 32'(iss_src[0]), 32'h0000ABCD);
    chk("R2 ready value kept", 32'(iss_src[1]), 32'h00001111);
    chk("R3 dst after wake", 32'(iss_dst), 1);
    idle(1);

    // R4: broadcast coincides with insertion
    step(1, 4'd3, 2'b00, 4'd5, 4'd6, 0, 0, 1, 4'd5, 16'h0505, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 4'd6, 16'h0606, 0);
    chk("R4 same-cycle capture valid", 32'(iss_valid), 1);
    chk("R4 same-cycle capture value", 32'(iss_src[0]), 32'h00000505);
    idle(1);

    // R9 and R8: fill under back-pressure
    for (int k = 0; k < N; k++)
      step(1, TAG_W'(4 + k), 2'b11, 0, 0, 16'(k), 16'(k + 16), 0, 0, 0, 0);
    chk("R9 full stalls", 32'(ins_ready), 0);
    step(1, 4'd8, 2'b11, 0, 0, 16'hDEAD, 16'hBEEF, 0, 0, 0, 0);
    chk("R8 held while stalled", 32'(iss_valid), 1);
    chk("R6 oldest first", 32'(iss_dst), 4);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 freed after issue", 32'(ins_ready), 1);
    chk("R6 next oldest", 32'(iss_dst), 5);
    step(1, 4'd9, 2'b11, 0, 0, 16'h0909, 16'h0919, 0, 0, 0, 0);
    for (int k = 0; k < N + 1; k++) begin
      if (iss_valid) chk("R9 ignored insert absent", 32'(iss_dst == 4'd8), 0);
      idle(1);
    end

    // mixed traffic
    for (int c = 0; c < 4000; c++) begin
      step($urandom_range(0, 99) < 60, TAG_W'($urandom), 2'($urandom),
           TAG_W'($urandom_range(0, 7)), TAG_W'($urandom_range(0, 7)),
           16'($urandom), 16'($urandom),
           $urandom_range(0, 99) < 50, TAG_W'($urandom_range(0, 7)), 16'($urandom),
           $urandom_range(0, 99) < 70);
    end
    for (int c = 0; c < 64; c++)
      step(0, 0, 0, 0, 0, 0, 0, 1, TAG_W'(c % 8), 16'($urandom), 1);
    idle(1);
    chk("R1 drained", 32'(ins_ready), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule